// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

A synchronous binary counter whose width is set by a parameter (4 bits by default). Every bit of the count updates together on the rising clock edge when the active-low count enable is asserted. A single direction input selects incrementing or decrementing. The count wraps modulo 2^WIDTH in both directions. An active-low parallel load forces the data inputs onto the count asynchronously, whatever the clock level, and overrides counting for as long as it is held low. The load can preset the counter to a chosen value, so the stage can serve as a modulo-N divider.

Two outputs let stages be chained. The terminal-count flag is high for the whole cycle in which the count sits at the limit for the present direction: all ones when counting up, zero when counting down. It is decoded without a register, so it follows a direction change at once. The ripple-clock output is an active-low pulse. It is low only in the low phase of the clock, only while the limit holds and counting is enabled. It can clock a following stage that shares the enable, or it can feed that stage's enable when both stages share a clock. The terminal-count flag, gated with the enable, gives a look-ahead enable for the next stage in a shared-clock chain.

Top module: `updn_cascade_counter`

## Requirements
- R1: With `en_n` low and `down` low, each rising clock edge adds one to `q`. All ones wraps to zero.
- R2: With `en_n` low and `down` high, each rising clock edge subtracts one from `q`. Zero wraps to all ones.
- R3: With `en_n` high, `q` keeps its value across rising clock edges in either direction.
- R4: While `load_n` is low, `q` equals `din` immediately, in either clock phase. Rising edges that arrive while `load_n` is low do not change `q`.
- R5: `term_flag` is 1 exactly when `down` is 0 and `q` is all ones, or when `down` is 1 and `q` is zero. It follows a change of `down` without waiting for a clock edge.
- R6: `ripple_n` is 0 exactly when `clk` is 0, `en_n` is 0 and `term_flag` is 1. It is 1 throughout the high phase of the clock and whenever the stage is disabled.
- R7: Two stages that share `en_n`, `down` and `load_n`, with the first stage's `ripple_n` driving the second stage's `clk`, count as one 2×WIDTH-bit counter. The second stage holds the upper bits.
- R8: Two stages on one clock, with the second stage's `en_n` driven by `en_n OR NOT term_flag` of the first stage, count as one 2×WIDTH-bit counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count advances on its rising edge |
| load_n | input | 1 | Active-low asynchronous parallel load |
| en_n | input | 1 | Active-low count enable |
| down | input | 1 | Direction: 0 counts up, 1 counts down |
| din | input | WIDTH | Preset value taken while `load_n` is low |
| q | output | WIDTH | Current count |
| term_flag | output | 1 | High while the count is at the limit for the present direction |
| ripple_n | output | 1 | Active-low cascade pulse, gated by the low phase of the clock |

## Verification
The bench builds four instances, all at the default width of 4. Two of them are chained through the ripple-clock output and two through the look-ahead enable, and both pairs are compared against one 8-bit reference value. With a 4-bit stage, both wrap points and the carry or borrow between the nibbles are reached within a few dozen cycles. Enable and direction change only during the clock's high phase. Loads are placed in both clock phases and held across an edge.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;

  // Count direction as seen by the datapath.
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

endpackage

// File: rtl/udc_count_reg.sv
module udc_count_reg
  import updn_cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             load_n,
  input  logic             step_en,
  input  dir_e             dir,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // Next value for one step; wraps modulo 2^WIDTH.
  function automatic logic [WIDTH-1:0] next_val(input logic [WIDTH-1:0] cur,
                                                input dir_e d);
    return (d == DIR_DOWN) ? cur - ONE : cur + ONE;
  endfunction

  // Asynchronous preset has priority over counting.
  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n)      q <= din;
    else if (step_en) q <= next_val(q, dir);
  end

endmodule

// File: rtl/udc_limit_dec.sv
module udc_limit_dec
  import updn_cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  dir_e             dir,
  output logic             at_limit
);

  // Each bit must equal the limit bit of the present direction:
  // 1 when counting up, 0 when counting down.
  logic [WIDTH-1:0] bit_match;

  for (genvar i = 0; i < WIDTH; i++) begin : g_match
    assign bit_match[i] = q[i] ^ dir;
  end

  assign at_limit = &bit_match;

endmodule

// File: rtl/udc_ripple_gate.sv
module udc_ripple_gate (
  input  logic clk,
  input  logic at_limit,
  input  logic step_en,
  output logic ripple_n
);

  // Low only in the clock's low phase while the limit holds and counting is on.
  assign ripple_n = ~(at_limit & step_en & ~clk);

endmodule

// File: rtl/updn_cascade_counter.sv
module updn_cascade_counter
  import updn_cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             load_n,
  input  logic             en_n,
  input  logic             down,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             term_flag,
  output logic             ripple_n
);

  // Named internal events
  dir_e count_dir;
  logic count_step;
  logic at_limit;

  assign count_dir  = down ? DIR_DOWN : DIR_UP;
  assign count_step = ~en_n;

  udc_count_reg #(.WIDTH(WIDTH)) u_reg (
    .clk     (clk),
    .load_n  (load_n),
    .step_en (count_step),
    .dir     (count_dir),
    .din     (din),
    .q       (q)
  );

  udc_limit_dec #(.WIDTH(WIDTH)) u_limit (
    .q        (q),
    .dir      (count_dir),
    .at_limit (at_limit)
  );

  udc_ripple_gate u_ripple (
    .clk      (clk),
    .at_limit (at_limit),
    .step_en  (count_step),
    .ripple_n (ripple_n)
  );

  assign term_flag = at_limit;

endmodule

// File: rtl/udc_checker.sv
module udc_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             load_n,
  input logic             en_n,
  input logic             down,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             term_flag,
  input logic             ripple_n
);

  // Set by any load; cleared by the next edge. Sampled at an edge, it shows
  // whether a load happened since the previous edge.
  logic load_seen;
  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n) load_seen <= 1'b1;
    else         load_seen <= 1'b0;
  end

  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!load_n)
    (!en_n && !down) |=> (load_seen || q == $past(q) + WIDTH'(1))); // R1

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!load_n)
    (!en_n && down) |=> (load_seen || q == $past(q) - WIDTH'(1))); // R2

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!load_n)
    en_n |=> (load_seen || $stable(q))); // R3

  AST_LOAD_FORCES: assert property (@(posedge clk)
    !load_n |-> q == din); // R4

  AST_TERM_UP_LIMIT: assert property (@(posedge clk) disable iff (!load_n)
    (!down && q == '1) |-> term_flag); // R5

  AST_TERM_DOWN_LIMIT: assert property (@(posedge clk) disable iff (!load_n)
    (down && q == '0) |-> term_flag); // R5

  AST_TERM_ONLY_AT_LIMIT: assert property (@(posedge clk) disable iff (!load_n)
    term_flag |-> (q == '1 || q == '0)); // R5

  AST_RIPPLE_LOW_PHASE: assert property (@(posedge clk) disable iff (!load_n)
    ripple_n == !(term_flag && !en_n)); // R6

  AST_RIPPLE_HIGH_PHASE: assert property (@(negedge clk) disable iff (!load_n)
    ripple_n); // R6

endmodule

bind updn_cascade_counter udc_checker #(.WIDTH(WIDTH)) u_checker (
  .clk       (clk),
  .load_n    (load_n),
  .en_n      (en_n),
  .down      (down),
  .din       (din),
  .q         (q),
  .term_flag (term_flag),
  .ripple_n  (ripple_n)
);

// File: tb/tb_updn_cascade_counter.sv
module tb_updn_cascade_counter;

  logic       clk = 1'b0;
  logic       load_n = 1'b0;
  logic       en_n = 1'b1;
  logic       down = 1'b0;
  logic [7:0] ld_val = 8'h00;
  logic [7:0] exp_cnt = 8'h00;

  logic [3:0] a0q, a1q, b0q, b1q;
  logic       a0t, a1t, b0t, b1t;
  logic       a0r, a1r, b0r, b1r;
  logic       b1_en_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  // Ripple-clock chain (R7); dut is its low stage
  updn_cascade_counter #(.WIDTH(4)) dut (
    .clk(clk), .load_n(load_n), .en_n(en_n), .down(down), .din(ld_val[3:0]),
    .q(a0q), .term_flag(a0t), .ripple_n(a0r));
  updn_cascade_counter #(.WIDTH(4)) a_hi (
    .clk(a0r), .load_n(load_n), .en_n(en_n), .down(down), .din(ld_val[7:4]),
    .q(a1q), .term_flag(a1t), .ripple_n(a1r));

  // Look-ahead chain (R8)
  assign b1_en_n = en_n | ~b0t;
  updn_cascade_counter #(.WIDTH(4)) b_lo (
    .clk(clk), .load_n(load_n), .en_n(en_n), .down(down), .din(ld_val[3:0]),
    .q(b0q), .term_flag(b0t), .ripple_n(b0r));
  updn_cascade_counter #(.WIDTH(4)) b_hi (
    .clk(clk), .load_n(load_n), .en_n(b1_en_n), .down(down), .din(ld_val[7:4]),
    .q(b1q), .term_flag(b1t), .ripple_n(b1r));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic align();
    @(posedge clk); #2;
  endtask

  // Load in the high phase; checks the value appears at once.
  task automatic do_load(input logic [7:0] v);
    ld_val = v; load_n = 1'b0; #1;
    chk({a1q, a0q} == v, "R4", {a1q, a0q}, v);
    chk({b1q, b0q} == v, "R4", {b1q, b0q}, v);
    exp_cnt = v;
    #1 load_n = 1'b1;
  endtask

  // One clock with given enable/direction; called in the high phase.
  task automatic tick(input logic en_v, input logic dn_v);
    logic  lim;
    string r_lo;
    en_n = en_v; down = dn_v;
    @(negedge clk); #2;
    lim = dn_v ? (exp_cnt[3:0] == 4'h0) : (exp_cnt[3:0] == 4'hF);
    chk(a0t == lim, "R5", a0t, lim);
    chk(a0r == !(lim && !en_v), "R6", a0r, !(lim && !en_v));
    @(posedge clk); #2;
    if (!en_v) exp_cnt = dn_v ? exp_cnt - 8'd1 : exp_cnt + 8'd1;
    r_lo = en_v ? "R3" : (dn_v ? "R2" : "R1");
    chk(a0q == exp_cnt[3:0], r_lo, a0q, exp_cnt[3:0]);
    chk({a1q, a0q} == exp_cnt, "R7", {a1q, a0q}, exp_cnt);
    chk({b1q, b0q} == exp_cnt, "R8", {b1q, b0q}, exp_cnt);
    chk(a0r == 1'b1, "R6", a0r, 1);
  endtask

  task automatic t_reset_state();
    repeat (2) @(posedge clk);
    #2;
    chk(a0q == 4'h0, "R4", a0q, 0);
    chk(a0t == 1'b0, "R5", a0t, 0);
    chk(a0r == 1'b1, "R6", a0r, 1);
    load_n = 1'b1;
  endtask

  task automatic t_count_up();
    do_load(8'h0C);
    for (int i = 0; i < 22; i++) tick(1'b0, 1'b0);   // carries 0x0F -> 0x10
    do_load(8'hFD);
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b0);    // R1 wrap 0xFF -> 0x00
    chk(exp_cnt == 8'h02, "R1", exp_cnt, 8'h02);
  endtask

  task automatic t_count_down();
    do_load(8'h12);
    for (int i = 0; i < 20; i++) tick(1'b0, 1'b1);   // R2 borrow and wrap
    chk({a1q, a0q} == 8'hFE, "R2", {a1q, a0q}, 8'hFE);
  endtask

  task automatic t_hold();
    do_load(8'h5A);
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0);
    for (int i = 0; i < 2; i++) tick(1'b1, 1'b1);
    do_load(8'h0F);
    tick(1'b1, 1'b0);   // at limit but disabled: ripple stays high (R6), count held (R3)
  endtask

  task automatic t_dir_flip();
    do_load(8'h3F);
    down = 1'b0; #1;
    chk(a0t == 1'b1, "R5", a0t, 1);
    down = 1'b1; #1;
    chk(a0t == 1'b0, "R5", a0t, 0);
    align();
    do_load(8'h30);
    #1 chk(a0t == 1'b1, "R5", a0t, 1);
    down = 1'b0; #1;
    chk(a0t == 1'b0, "R5", a0t, 0);
    align();
  endtask

  task automatic t_low_phase_load();
    en_n = 1'b1;
    @(negedge clk); #3;
    ld_val = 8'h9C; load_n = 1'b0; #1;
    chk(clk == 1'b0, "R4", clk, 0);
    chk({a1q, a0q} == 8'h9C, "R4", {a1q, a0q}, 8'h9C);
    #2 load_n = 1'b1;
    exp_cnt = 8'h9C;
    align();
    tick(1'b0, 1'b0);
  endtask

  task automatic t_load_override();
    en_n = 1'b0; down = 1'b0;
    ld_val = 8'h47; load_n = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    chk({a1q, a0q} == 8'h47, "R4", {a1q, a0q}, 8'h47);
    chk({b1q, b0q} == 8'h47, "R4", {b1q, b0q}, 8'h47);
    load_n = 1'b1;
    exp_cnt = 8'h47;
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b1);
  endtask

  initial begin
    t_reset_state();
    align();
    t_count_up();
    t_count_down();
    t_hold();
    t_dir_flip();
    t_low_phase_load();
    t_load_override();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule